// File: doc/BRIEF.md
# Debug Breakpoint and Background Halt Controller

This block decides when the CPU must stop running user code and enter background debug mode. It holds an 8-bit debug configuration and status register that a debug host reaches only through two serial commands, a status read and a control write. The CPU memory bus never reaches it. A separate 16-bit breakpoint address register is loaded through its own host strobe.

When breakpoints are armed, the block compares every CPU address against the breakpoint address. In force mode, any matching bus cycle makes a halt pending, and the halt happens at the next instruction boundary. In tag mode, a matching opcode fetch marks that opcode in a shadow of the CPU instruction queue. The halt happens only if the marked opcode reaches the end of the queue. In that case the block blocks its execution in the same cycle. Marks that are flushed before issue are discarded.

The serial protocol, the CPU core and the instruction queue are modelled as single-cycle strobes. Two target resets exist: a normal reset clears the register, and a reset into background mode leaves the target halted with debug enabled.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After the asynchronous reset is released, the status register reads 8'h00, and `halt_req`, `bdm_active`, `clk_sel` and `exec_inhibit` are 0.
- R2: One clock after `hst_rd_stb`, `hst_rd_data` holds the register as it stood before that edge: bit 7 enable, bit 6 active, bit 5 breakpoint enable, bit 4 mode select (1 force, 0 tag), bit 3 clock select, bits 2..0 always 0. Between reads `hst_rd_data` is held.
- R3: A control write (`hst_wr_stb`) loads bits 5, 4 and 3 from `hst_wr_data`. Bit 7 can be set to 1 by a write but is never cleared by one. Writes to bits 6 and 2..0 are ignored.
- R4: While the enable bit is 0, `halt_req` never asserts and `bdm_active` never rises through a breakpoint. Status reads and control writes still work.
- R5: While the breakpoint enable bit is 0, address matches cause no halt in either mode.
- R6: With enable, breakpoint enable and mode select all at 1, a cycle with `cpu_addr_vld` and `cpu_addr` equal to the breakpoint address makes a halt pending. The halt fires on the first `cpu_insn_bnd` in a later cycle: `halt_req` and `bdm_active` rise at the edge that samples that boundary. A boundary in the same cycle as the match does not fire it.
- R7: With mode select at 0 and enable and breakpoint enable at 1, a `cpu_opfetch` whose address matches tags that opcode. When the tagged opcode is at the queue head and `cpu_q_issue` is high, `exec_inhibit` is 1 in that cycle and `halt_req` rises at the following edge. Untagged opcodes issue with `exec_inhibit` at 0.
- R8: `cpu_q_flush` discards every queued opcode and tag and takes priority over an issue or fetch in the same cycle. A flushed tag never causes a halt.
- R9: `hst_resume` while active clears `bdm_active` at the next edge. While not active it has no effect.
- R10: `sys_rst_req` with `sys_rst_bkgd` = 0 makes the register read 8'h00. With `sys_rst_bkgd` = 1 it makes the register read 8'hC8 (enable, active and clock select set). Either form drops pending halts and tags, and neither changes the breakpoint address.
- R11: Each halt raises `halt_req` for exactly one clock. No halt is raised while `bdm_active` is 1.
- R12: `hst_bkpt_wr_stb` loads the 16-bit breakpoint address from `hst_bkpt_data`, and later matches compare against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| sys_rst_req | input | 1 | Synchronous target reset strobe |
| sys_rst_bkgd | input | 1 | Qualifies `sys_rst_req`: 1 resets into background mode |
| hst_rd_stb | input | 1 | Host status-read command |
| hst_rd_data | output | 8 | Status captured by the last read |
| hst_wr_stb | input | 1 | Host control-write command |
| hst_wr_data | input | 8 | Control-write data |
| hst_bkpt_wr_stb | input | 1 | Host breakpoint-address write strobe |
| hst_bkpt_data | input | 16 | Breakpoint address data |
| hst_resume | input | 1 | Host command to leave background mode |
| cpu_addr | input | 16 | CPU address bus |
| cpu_addr_vld | input | 1 | A bus cycle is in progress on `cpu_addr` |
| cpu_opfetch | input | 1 | The current cycle fetches an opcode into the queue |
| cpu_insn_bnd | input | 1 | An instruction boundary occurs this cycle |
| cpu_q_issue | input | 1 | The queue-head opcode reaches execution |
| cpu_q_flush | input | 1 | The instruction queue is discarded |
| halt_req | output | 1 | One-clock request to enter background mode |
| bdm_active | output | 1 | Background mode is active |
| clk_sel | output | 1 | Clock-select control bit |
| exec_inhibit | output | 1 | The issuing opcode is tagged and must not execute |

## Verification
The hardest case to reach is a tag that must survive several queue moves before it counts. The tagged opcode has to enter behind untagged ones and move to the head through issues. It must not be lost to a flush on the way, and the host must have chosen tag mode with both enables set. Random strobes rarely line up that way. Directed sequences therefore build the queue contents on purpose: an untagged fetch, then a tagged fetch, then issues. Another directed sequence tags and then flushes. The random phase draws addresses mostly from the breakpoint value and its neighbour, so that matches, fetches, issues and flushes mix freely, and a bench model of the queue follows every tag.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CSR_W   = 8;
  localparam int B_EN    = 7;
  localparam int B_ACT   = 6;
  localparam int B_BKEN  = 5;
  localparam int B_FTS   = 4;
  localparam int B_CLK   = 3;
  localparam logic [CSR_W-1:0] CSR_BKGD_RST = 8'hC8;

  typedef struct packed {
    logic en;
    logic act;
    logic bken;
    logic fts;
    logic clksel;
  } dbg_cfg_t;
endpackage

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_halt_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sys_rst_req,
  input  logic             sys_rst_bkgd,
  input  logic             wr_stb,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             rd_stb,
  input  logic             halt_set,
  input  logic             resume,
  output dbg_cfg_t         cfg,
  output logic [CSR_W-1:0] rd_data
);
  dbg_cfg_t         cfg_q, cfg_d;
  logic [CSR_W-1:0] rd_q, rd_d, status;
  logic             cfg_upd;
  logic             wr_unused;

  assign wr_unused = ^{wr_data[B_ACT], wr_data[2:0]};

  always_comb begin
    status        = '0;
    status[B_EN]  = cfg_q.en;
    status[B_ACT] = cfg_q.act;
    status[B_BKEN]= cfg_q.bken;
    status[B_FTS] = cfg_q.fts;
    status[B_CLK] = cfg_q.clksel;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (sys_rst_req) begin
      cfg_d = '0;
      if (sys_rst_bkgd) begin
        cfg_d.en     = 1'b1;
        cfg_d.act    = 1'b1;
        cfg_d.clksel = 1'b1;
      end
    end else begin
      if (halt_set)
        cfg_d.act = 1'b1;
      else if (resume)
        cfg_d.act = 1'b0;
      if (wr_stb) begin
        cfg_d.en     = cfg_q.en | wr_data[B_EN];
        cfg_d.bken   = wr_data[B_BKEN];
        cfg_d.fts    = wr_data[B_FTS];
        cfg_d.clksel = wr_data[B_CLK];
      end
    end
  end

  assign cfg_upd = sys_rst_req | halt_set | resume | wr_stb;
  assign rd_d    = status;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q <= '0;
    end else if (cfg_upd) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rd_q <= '0;
    end else if (rd_stb) begin
      rd_q <= rd_d;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = rd_q;

  // R3: enable is sticky against everything except a normal target reset
  p_en_sticky_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (cfg_q.en && !sys_rst_req) |=> cfg_q.en);

  // R9: resume while active leaves background mode
  p_resume_clears_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (cfg_q.act && resume && !halt_set && !sys_rst_req) |=> !cfg_q.act);

  // R10: background reset value
  p_bkgd_rst_val_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (sys_rst_req && sys_rst_bkgd) |=> (status == CSR_BKGD_RST));

  // R10: normal reset value
  p_norm_rst_val_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (sys_rst_req && !sys_rst_bkgd) |=> (status == '0));
endmodule

// File: rtl/dbg_bkpt_match.sv
module dbg_bkpt_match
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sys_rst_req,
  input  logic              bkpt_wr_stb,
  input  logic [ADDR_W-1:0] bkpt_wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_addr_vld,
  input  logic              cpu_opfetch,
  input  dbg_cfg_t          cfg,
  input  logic              halt_now,
  output logic              force_pend,
  output logic              fetch_tag
);
  logic [ADDR_W-1:0] bkpt_q;
  logic              pend_q, pend_d;
  logic              addr_hit;
  logic              arm_force;
  logic              arm_tag;

  assign addr_hit  = (cpu_addr == bkpt_q);
  assign arm_force = cfg.en & cfg.bken & cfg.fts & ~cfg.act & ~sys_rst_req;
  assign arm_tag   = cfg.en & cfg.bken & ~cfg.fts;

  always_comb begin
    pend_d = arm_force & ~halt_now & (pend_q | (cpu_addr_vld & addr_hit));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bkpt_q <= '0;
    end else if (bkpt_wr_stb) begin
      bkpt_q <= bkpt_wr_data;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign force_pend = pend_q;
  assign fetch_tag  = cpu_opfetch & addr_hit & arm_tag;

  // R5: with breakpoints disabled nothing stays pending
  p_bken_off_no_pend_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !cfg.bken |=> !pend_q);

  // R5: no tag is produced while breakpoints are disabled
  p_bken_off_no_tag_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !cfg.bken |-> !fetch_tag);

  // R12: a new breakpoint address is taken at the next edge
  p_bkpt_load_r12: assert property (@(posedge clk) disable iff (!arst_n)
    bkpt_wr_stb |=> (bkpt_q == $past(bkpt_wr_data)));
endmodule

// File: rtl/dbg_tag_queue.sv
module dbg_tag_queue #(
  parameter int QDEPTH = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clear,
  input  logic push,
  input  logic push_tag,
  input  logic issue,
  output logic exec_inhibit
);
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QDEPTH);

  logic [QDEPTH-1:0] tags_q, tags_d, tags_shift;
  logic [CNT_W-1:0]  cnt_q, cnt_d, wr_idx;
  logic              not_empty, full, pop, push_ok;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CNT_FULL);
  assign pop       = issue & ~clear & not_empty;
  assign push_ok   = push & ~clear & (~full | pop);
  assign wr_idx    = cnt_q - CNT_W'(pop);

  genvar gi;
  generate
    for (gi = 0; gi < QDEPTH; gi++) begin : g_slot
      if (gi == QDEPTH - 1) begin : g_top
        assign tags_shift[gi] = pop ? 1'b0 : tags_q[gi];
      end else begin : g_mid
        assign tags_shift[gi] = pop ? tags_q[gi+1] : tags_q[gi];
      end
      always_comb begin
        if (clear)
          tags_d[gi] = 1'b0;
        else if (push_ok && (wr_idx == CNT_W'(gi)))
          tags_d[gi] = push_tag;
        else
          tags_d[gi] = tags_shift[gi];
      end
    end
  endgenerate

  always_comb begin
    if (clear)
      cnt_d = '0;
    else
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tags_q <= '0;
      cnt_q  <= '0;
    end else begin
      tags_q <= tags_d;
      cnt_q  <= cnt_d;
    end
  end

  assign exec_inhibit = pop & tags_q[0];

  // R8: a flush leaves the shadow queue empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!arst_n)
    clear |=> (cnt_q == '0) && (tags_q == '0));

  // R7: the occupancy never exceeds the queue depth
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= CNT_FULL);

  // R8: no inhibit during a flush cycle
  p_flush_no_inhibit_r8: assert property (@(posedge clk) disable iff (!arst_n)
    clear |-> !exec_inhibit);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_req,
  input  logic              sys_rst_bkgd,
  input  logic              hst_rd_stb,
  output logic [CSR_W-1:0]  hst_rd_data,
  input  logic              hst_wr_stb,
  input  logic [CSR_W-1:0]  hst_wr_data,
  input  logic              hst_bkpt_wr_stb,
  input  logic [ADDR_W-1:0] hst_bkpt_data,
  input  logic              hst_resume,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_addr_vld,
  input  logic              cpu_opfetch,
  input  logic              cpu_insn_bnd,
  input  logic              cpu_q_issue,
  input  logic              cpu_q_flush,
  output logic              halt_req,
  output logic              bdm_active,
  output logic              clk_sel,
  output logic              exec_inhibit
);
  logic [1:0] rst_sync_q;
  logic       arst_n;
  dbg_cfg_t   cfg;
  logic       force_pend, fetch_tag, inhibit;
  logic       halt_force, halt_tag, halt_now;
  logic       halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign arst_n = rst_sync_q[1];

  dbg_csr u_csr (
    .clk          (clk),
    .arst_n       (arst_n),
    .sys_rst_req  (sys_rst_req),
    .sys_rst_bkgd (sys_rst_bkgd),
    .wr_stb       (hst_wr_stb),
    .wr_data      (hst_wr_data),
    .rd_stb       (hst_rd_stb),
    .halt_set     (halt_now),
    .resume       (hst_resume),
    .cfg          (cfg),
    .rd_data      (hst_rd_data)
  );

  dbg_bkpt_match #(.ADDR_W(ADDR_W)) u_match (
    .clk          (clk),
    .arst_n       (arst_n),
    .sys_rst_req  (sys_rst_req),
    .bkpt_wr_stb  (hst_bkpt_wr_stb),
    .bkpt_wr_data (hst_bkpt_data),
    .cpu_addr     (cpu_addr),
    .cpu_addr_vld (cpu_addr_vld),
    .cpu_opfetch  (cpu_opfetch),
    .cfg          (cfg),
    .halt_now     (halt_now),
    .force_pend   (force_pend),
    .fetch_tag    (fetch_tag)
  );

  dbg_tag_queue #(.QDEPTH(QDEPTH)) u_queue (
    .clk          (clk),
    .arst_n       (arst_n),
    .clear        (cpu_q_flush | sys_rst_req),
    .push         (cpu_opfetch),
    .push_tag     (fetch_tag),
    .issue        (cpu_q_issue),
    .exec_inhibit (inhibit)
  );

  assign halt_force = force_pend & cpu_insn_bnd & ~cfg.act;
  assign halt_tag   = inhibit & ~cfg.act;
  assign halt_now   = (halt_force | halt_tag) & ~sys_rst_req;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_now;
    end
  end

  assign halt_req     = halt_q;
  assign bdm_active   = cfg.act;
  assign clk_sel      = cfg.clksel;
  assign exec_inhibit = inhibit;

  // R11: the halt request is a single-clock pulse
  p_halt_pulse_r11: assert property (@(posedge clk) disable iff (!arst_n)
    halt_req |=> !halt_req);

  // R6: the request and the active status rise together
  p_halt_active_r6: assert property (@(posedge clk) disable iff (!arst_n)
    halt_req |-> bdm_active);

  // R4: no halt without the enable bit
  p_halt_needs_en_r4: assert property (@(posedge clk) disable iff (!arst_n)
    halt_req |-> cfg.en);

  // R7: an inhibited issue while running turns into a halt
  p_inhibit_halts_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (exec_inhibit && !bdm_active && !sys_rst_req) |=> halt_req);

  // R11: no new halt while already active
  p_no_halt_active_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (bdm_active && !hst_resume) |=> !halt_req);
endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb_top;
  localparam int AW = 16;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          i_srst, i_bkgd, i_rd, i_wr, i_bwr, i_res;
  logic [7:0]    i_wdat;
  logic [AW-1:0] i_bdat, i_addr;
  logic          i_av, i_fetch, i_bnd, i_issue, i_flush;
  logic [7:0]    o_rd;
  logic          o_halt, o_act, o_clk, o_inh;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  bit          m_en, m_act, m_bken, m_fts, m_ck, m_pend, m_halt;
  bit [QD-1:0] m_tags;
  int          m_cnt;
  bit [AW-1:0] m_bkpt;
  bit [7:0]    m_rd;

  always #4 clk = ~clk;

  dbg_halt_ctrl #(.ADDR_W(AW), .QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(i_srst), .sys_rst_bkgd(i_bkgd),
    .hst_rd_stb(i_rd), .hst_rd_data(o_rd), .hst_wr_stb(i_wr), .hst_wr_data(i_wdat),
    .hst_bkpt_wr_stb(i_bwr), .hst_bkpt_data(i_bdat), .hst_resume(i_res),
    .cpu_addr(i_addr), .cpu_addr_vld(i_av), .cpu_opfetch(i_fetch),
    .cpu_insn_bnd(i_bnd), .cpu_q_issue(i_issue), .cpu_q_flush(i_flush),
    .halt_req(o_halt), .bdm_active(o_act), .clk_sel(o_clk), .exec_inhibit(o_inh)
  );

  task automatic check(input string lbl, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", lbl, got, exp);
    end
  endtask

  function automatic bit [7:0] stat_word();
    return {m_en, m_act, m_bken, m_fts, m_ck, 3'b000};
  endfunction

  task automatic idle();
    i_srst = 0; i_bkgd = 0; i_rd = 0; i_wr = 0; i_bwr = 0; i_res = 0;
    i_wdat = '0; i_bdat = '0; i_addr = '0; i_av = 0; i_fetch = 0;
    i_bnd = 0; i_issue = 0; i_flush = 0;
  endtask

  // inputs are set by the caller at a falling edge; this checks the comb
  // output, advances the model, and checks registered outputs one edge later
  task automatic step(input string lbl);
    bit exp_inh, hf, ht, hl, clr, pop, full, push, tg, mf, arm;
    #1;
    clr     = i_flush | i_srst;
    exp_inh = i_issue && !clr && (m_cnt != 0) && m_tags[0];
    check({lbl, " exec_inhibit"}, 32'(o_inh), 32'(exp_inh));
    hf = m_pend && i_bnd && !m_act;
    ht = exp_inh && !m_act;
    hl = (hf || ht) && !i_srst;
    mf  = i_av && (i_addr == m_bkpt);
    tg  = i_fetch && (i_addr == m_bkpt) && m_en && m_bken && !m_fts;
    arm = m_en && m_bken && m_fts && !m_act && !i_srst;
    if (i_rd) m_rd = stat_word();
    m_pend = arm && !hl && (m_pend || mf);
    pop  = i_issue && !clr && (m_cnt != 0);
    full = (m_cnt == QD);
    push = i_fetch && !clr && (!full || pop);
    if (clr) begin
      m_cnt = 0; m_tags = '0;
    end else begin
      if (pop) m_tags = m_tags >> 1;
      if (push) m_tags[m_cnt - int'(pop)] = tg;
      m_cnt = m_cnt + int'(push) - int'(pop);
    end
    if (i_srst) begin
      m_en = i_bkgd; m_act = i_bkgd; m_ck = i_bkgd; m_bken = 0; m_fts = 0;
    end else begin
      if (hl) m_act = 1;
      else if (i_res) m_act = 0;
      if (i_wr) begin
        m_en = m_en | i_wdat[7]; m_bken = i_wdat[5]; m_fts = i_wdat[4]; m_ck = i_wdat[3];
      end
    end
    m_halt = hl;
    if (i_bwr) m_bkpt = i_bdat;
    @(negedge clk);
    check({lbl, " hst_rd_data"}, 32'(o_rd), 32'(m_rd));
    check({lbl, " halt_req"},    32'(o_halt), 32'(m_halt));
    check({lbl, " bdm_active"},  32'(o_act), 32'(m_act));
    check({lbl, " clk_sel"},     32'(o_clk), 32'(m_ck));
    idle();
  endtask

  task automatic host_wr(input string lbl, input logic [7:0] d);
    i_wr = 1; i_wdat = d; step(lbl);
  endtask

  task automatic host_rd(input string lbl, input logic [7:0] exp);
    i_rd = 1; step(lbl);
    check({lbl, " read value"}, 32'(o_rd), 32'(exp));
  endtask

  task automatic resume(input string lbl);
    i_res = 1; step(lbl);
    check({lbl, " resume"}, 32'(o_act), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle();
    m_en = 0; m_act = 0; m_bken = 0; m_fts = 0; m_ck = 0; m_pend = 0;
    m_halt = 0; m_tags = '0; m_cnt = 0; m_bkpt = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: state after reset
    check("R1 halt_req", 32'(o_halt), 0);
    check("R1 bdm_active", 32'(o_act), 0);
    check("R1 clk_sel", 32'(o_clk), 0);
    check("R1 exec_inhibit", 32'(o_inh), 0);
    host_rd("R1", 8'h00);

    // R12: load breakpoint address
    i_bwr = 1; i_bdat = 16'h1234; step("R12");

    // R4: enable clear, force mode armed otherwise
    host_wr("R4", 8'h38);
    i_av = 1; i_addr = 16'h1234; step("R4");
    i_bnd = 1; step("R4");
    check("R4 no halt", 32'(o_halt), 0);
    host_rd("R4", 8'h38);

    // R5: enable set, breakpoints off
    host_wr("R5", 8'h90);
    i_av = 1; i_addr = 16'h1234; step("R5");
    i_bnd = 1; step("R5");
    check("R5 no halt", 32'(o_halt), 0);
    host_wr("R5", 8'h80);
    i_fetch = 1; i_av = 1; i_addr = 16'h1234; step("R5");
    i_issue = 1; step("R5");
    check("R5 tag mode off", 32'(o_halt), 0);

    // R6: force mode halt at next boundary
    host_wr("R6", 8'hB0);
    i_av = 1; i_addr = 16'h1234; step("R6");
    check("R6 pending only", 32'(o_halt), 0);
    i_bnd = 1; step("R6");
    check("R6 halt", 32'(o_halt), 1);
    check("R6 active", 32'(o_act), 1);
    step("R11");
    check("R11 single pulse", 32'(o_halt), 0);
    i_av = 1; i_addr = 16'h1234; step("R11");
    i_bnd = 1; step("R11");
    check("R11 no halt while active", 32'(o_halt), 0);
    resume("R9");
    i_av = 1; i_addr = 16'h1234; i_bnd = 1; step("R6");
    check("R6 same-cycle boundary", 32'(o_halt), 0);
    i_bnd = 1; step("R6");
    check("R6 later boundary", 32'(o_halt), 1);
    resume("R9");
    resume("R9");

    // R7: tag mode
    host_wr("R7", 8'hA0);
    i_fetch = 1; i_av = 1; i_addr = 16'h1000; step("R7");
    i_fetch = 1; i_av = 1; i_addr = 16'h1234; step("R7");
    i_issue = 1; step("R7");
    check("R7 untagged issue", 32'(o_halt), 0);
    i_issue = 1; #1;
    check("R7 inhibit", 32'(o_inh), 1);
    step("R7");
    check("R7 halt", 32'(o_halt), 1);
    resume("R9");

    // R8: flushed tag
    i_fetch = 1; i_av = 1; i_addr = 16'h1234; step("R8");
    i_flush = 1; i_issue = 1; step("R8");
    i_fetch = 1; i_av = 1; i_addr = 16'h2000; step("R8");
    i_issue = 1; step("R8");
    check("R8 no halt", 32'(o_halt), 0);

    // R3: write masking and sticky enable
    host_wr("R3", 8'h47);
    host_rd("R3", 8'h80);
    host_wr("R2", 8'h18);
    host_rd("R2", 8'h98);
    step("R2");
    check("R2 held", 32'(o_rd), 32'h98);

    // R10: target resets
    i_srst = 1; i_bkgd = 1; step("R10");
    host_rd("R10", 8'hC8);
    i_srst = 1; step("R10");
    host_rd("R10", 8'h00);
    host_wr("R10", 8'hB0);
    i_av = 1; i_addr = 16'h1234; step("R10");
    i_bnd = 1; step("R10");
    check("R10 bkpt kept", 32'(o_halt), 1);
    resume("R9");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      i_rd = ($urandom_range(0, 99) < 20);
      if ($urandom_range(0, 99) < 4) begin
        i_wr = 1; i_wdat = 8'($urandom());
      end
      if ($urandom_range(0, 99) < 2) begin
        i_bwr = 1; i_bdat = ($urandom_range(0, 1) != 0) ? 16'h1234 : 16'h1235;
      end
      i_res   = ($urandom_range(0, 99) < 10);
      i_addr  = (r < 45) ? 16'h1234 : (r < 80) ? 16'h1235 : 16'($urandom());
      i_av    = ($urandom_range(0, 99) < 60);
      i_fetch = ($urandom_range(0, 99) < 35);
      if (i_fetch) i_av = 1;
      i_bnd   = ($urandom_range(0, 99) < 30);
      i_issue = ($urandom_range(0, 99) < 30);
      i_flush = ($urandom_range(0, 99) < 4);
      if ($urandom_range(0, 999) < 5) begin
        i_srst = 1; i_bkgd = $urandom_range(0, 1);
      end
      step("R11 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule